// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel of a high-precision event timer. It watches a shared, free-running main count supplied from outside. It raises an interrupt request when that count reaches a programmed comparator value. The channel can fire once (one-shot) or at a fixed interval (periodic). It can work on the full 64-bit count or only on its low 32 bits, and it can signal either as a held level with a status bit or as a single-cycle pulse.

Software programs the channel through a narrow write port. A 2-bit selector picks the configuration word, the low half of the comparator or the high half of the comparator. A separate strobe acknowledges the status bit. The main counter, the address decode and the routing of the request to an interrupt controller all sit outside this block.

In periodic mode a comparator write reloads the interval. The comparator value itself is written only while a one-shot set-value control bit is set, and that bit clears itself after the write. After each match the comparator steps forward by the interval until it lies ahead of the count again. In 32-bit one-shot mode the channel also fires once when the low 32 bits of the count roll over from all-ones to zero, provided this happens before the match.

Top module: `ect_channel`

## Requirements
- R1: After reset the channel is disabled, the interval is zero, the wrap flag is clear, `irq_o` and `sts_o` are 0, and the comparator holds all-ones, so enabling the channel makes it fire when the count equals all-ones.
- R2: Writes select their target with `wr_sel_i`: 0 is the configuration word, 1 is the comparator low half, 2 is the comparator high half, and 3 is ignored. The configuration bits are: bit 0 channel enable, bit 1 periodic, bit 2 32-bit mode, bit 3 level type (0 = edge), and bit 4 set-value.
- R3: A comparator-half write loads the comparator when the channel is one-shot or set-value is 1. In periodic mode, a low-half write also loads the interval low half, with bit 31 forced to 0 in 32-bit mode. A high-half write with set-value 0 loads the interval high half instead, with bit 63 forced to 0. Set-value reads 0 after any comparator-half write.
- R4: The channel fires in the cycle the count equals the comparator. In 32-bit mode only the low 32 bits are compared.
- R5: On a periodic match with a nonzero interval, the comparator adds the interval, one addition per cycle, until the signed difference (comparator minus count, 32 or 64 bits wide) is positive. A match that lies beyond a 32-bit rollover is still reached.
- R6: In 32-bit one-shot mode the channel fires once when the low 32 bits of the count step from all-ones to zero. This happens only if the rollover comes after the channel was last armed and before its match. Arming means a comparator write, a rising channel enable, or a rising global enable.
- R7: In level mode a firing sets `sts_o` and holds `irq_o` high. In edge mode a firing gives a one-cycle `irq_o` pulse, one cycle after the matching count, and `sts_o` stays 0.
- R8: `sts_clr_i` clears `sts_o` and drops the level request, unless a new firing happens in the same cycle.
- R9: Setting 32-bit mode clears the upper 32 bits of the comparator and of the interval, and they stay clear while the mode is set.
- R10: `irq_o` is low, and no firing takes place, while `glb_en_i` or the channel enable is 0. The status bit is cleared while either enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 64 | Main counter value |
| glb_en_i | input | 1 | Global enable of the timer block |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 config, 1 comparator low, 2 comparator high |
| wr_data_i | input | 32 | Write data |
| sts_clr_i | input | 1 | Write-one acknowledge of the status bit |
| irq_o | output | 1 | Interrupt request |
| sts_o | output | 1 | Level-mode status bit |

## Verification
Every cycle, the assertions check the enable gating of the request, the holding of a level request while status is set, the absence of status in edge mode, the acknowledge, the self-clearing of set-value and the truncation to 32 bits. Other behaviours show only in the bench's scenarios. These are the match instant over a swept count, the pulse spacing of periodic mode, the catch-up after the count jumps past several intervals, the signed ordering across a 32-bit rollover, and the single rollover interrupt in 32-bit one-shot mode. The forcing of interval bit 31 to zero also shows only there.

// File: rtl/ect_pkg.sv
package ect_pkg;
  typedef enum logic [1:0] {
    SEL_CFG    = 2'd0,
    SEL_CMP_LO = 2'd1,
    SEL_CMP_HI = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;

  // packed MSB first: en is bit 0
  typedef struct packed {
    logic setv;
    logic lvl;
    logic m32;
    logic per;
    logic en;
  } ch_cfg_t;

  localparam int unsigned CFG_W = $bits(ch_cfg_t);
endpackage

// File: rtl/ect_regs.sv
module ect_regs
  import ect_pkg::*;
#(
  parameter  int unsigned HALF_W = 32,
  localparam int unsigned CNT_W  = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [HALF_W-1:0] wr_data_i,
  output ch_cfg_t           cfg_o,
  output logic [CNT_W-1:0]  period_o,
  output logic              ld_lo_o,
  output logic              ld_hi_o,
  output logic              trunc_o,
  output logic              arm_o
);
  ch_cfg_t          cfg_q, wcfg;
  logic [CNT_W-1:0] period_q;
  wr_sel_e          sel;
  logic             wr_cfg, wr_lo, wr_hi, cmp_direct;
  logic [HALF_W-1:0] data_nomsb;

  assign sel        = wr_sel_e'(wr_sel_i);
  assign wr_cfg     = wr_en_i && (sel == SEL_CFG);
  assign wr_lo      = wr_en_i && (sel == SEL_CMP_LO);
  assign wr_hi      = wr_en_i && (sel == SEL_CMP_HI);
  assign wcfg       = ch_cfg_t'(wr_data_i[CFG_W-1:0]);
  assign data_nomsb = {1'b0, wr_data_i[HALF_W-2:0]};
  assign cmp_direct = !cfg_q.per || cfg_q.setv;

  assign ld_lo_o = wr_lo && cmp_direct;
  assign ld_hi_o = wr_hi && cmp_direct;
  assign trunc_o = wr_cfg && wcfg.m32;
  assign arm_o   = wr_lo || wr_hi || (wr_cfg && wcfg.en && !cfg_q.en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      period_q <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_q <= wcfg;
        if (wcfg.m32) period_q[CNT_W-1:HALF_W] <= '0;
      end
      if (wr_lo || wr_hi) cfg_q.setv <= 1'b0;
      if (wr_lo && cfg_q.per)
        period_q[HALF_W-1:0] <= cfg_q.m32 ? data_nomsb : wr_data_i;
      if (wr_hi && cfg_q.per && !cfg_q.setv)
        period_q[CNT_W-1:HALF_W] <= cfg_q.m32 ? '0 : data_nomsb;
    end
  end

  assign cfg_o    = cfg_q;
  assign period_o = period_q;
endmodule

// File: rtl/ect_cmp.sv
module ect_cmp #(
  parameter  int unsigned HALF_W = 32,
  localparam int unsigned CNT_W  = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              glb_en_i,
  input  logic              active_i,
  input  logic              per_i,
  input  logic              m32_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic              trunc_i,
  input  logic              arm_i,
  input  logic [HALF_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              match_o,
  output logic              wrap_o
);
  logic [CNT_W-1:0]  cmp_q, cmp_d, diff_w, sum_w;
  logic [HALF_W-1:0] cnt_lo, cmp_lo, diff_n;
  logic              pend_q, wflag_q, ones_q, glb_q;
  logic              eq, behind, adv, arm;

  assign cnt_lo = count_i[HALF_W-1:0];
  assign cmp_lo = cmp_q[HALF_W-1:0];
  assign eq     = m32_i ? (cnt_lo == cmp_lo) : (count_i == cmp_q);
  assign match_o = active_i && eq;

  // signed ordering, safe across wraparound
  assign diff_w = cmp_q - count_i;
  assign diff_n = cmp_lo - cnt_lo;
  assign behind = m32_i ? (diff_n[HALF_W-1] || diff_n == '0)
                        : (diff_w[CNT_W-1] || diff_w == '0);
  assign adv = active_i && per_i && (period_i != '0) && (match_o || (pend_q && behind));
  assign sum_w = cmp_q + period_i;

  assign wrap_o = active_i && m32_i && !per_i && wflag_q && ones_q && (cnt_lo == '0);
  assign arm    = arm_i || (glb_en_i && !glb_q);

  always_comb begin
    cmp_d = cmp_q;
    if (ld_lo_i || ld_hi_i) begin
      if (ld_lo_i) cmp_d[HALF_W-1:0] = wr_data_i;
      if (ld_hi_i) cmp_d[CNT_W-1:HALF_W] = m32_i ? '0 : wr_data_i;
    end else if (trunc_i) begin
      cmp_d[CNT_W-1:HALF_W] = '0;
    end else if (adv) begin
      cmp_d = m32_i ? {{HALF_W{1'b0}}, sum_w[HALF_W-1:0]} : sum_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q   <= '1;
      pend_q  <= 1'b0;
      wflag_q <= 1'b0;
      ones_q  <= 1'b0;
      glb_q   <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      pend_q <= adv;
      ones_q <= &cnt_lo;
      glb_q  <= glb_en_i;
      if (arm) wflag_q <= 1'b1;
      else if (match_o || wrap_o) wflag_q <= 1'b0;
    end
  end

  assign cmp_o = cmp_q;
endmodule

// File: rtl/ect_irq.sv
module ect_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic active_i,
  input  logic lvl_i,
  input  logic sts_clr_i,
  output logic irq_o,
  output logic sts_o
);
  logic sts_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire_i && !lvl_i;
      if (!active_i || !lvl_i) sts_q <= 1'b0;
      else if (fire_i)         sts_q <= 1'b1;
      else if (sts_clr_i)      sts_q <= 1'b0;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = active_i && (lvl_i ? sts_q : pulse_q);
endmodule

// File: rtl/ect_channel.sv
module ect_channel
  import ect_pkg::*;
#(
  parameter  int unsigned HALF_W = 32,
  localparam int unsigned CNT_W  = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              glb_en_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic              sts_clr_i,
  output logic              irq_o,
  output logic              sts_o
);
  ch_cfg_t          cfg;
  logic [CNT_W-1:0] period, cmp_val;
  logic             ld_lo, ld_hi, trunc, arm, active, match, wrap, fire;

  assign active = cfg.en && glb_en_i;
  assign fire   = match || wrap;

  ect_regs #(.HALF_W(HALF_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .cfg_o(cfg), .period_o(period), .ld_lo_o(ld_lo), .ld_hi_o(ld_hi),
    .trunc_o(trunc), .arm_o(arm)
  );

  ect_cmp #(.HALF_W(HALF_W)) u_cmp (
    .clk_i, .rst_ni, .count_i, .glb_en_i, .active_i(active),
    .per_i(cfg.per), .m32_i(cfg.m32), .period_i(period),
    .ld_lo_i(ld_lo), .ld_hi_i(ld_hi), .trunc_i(trunc), .arm_i(arm),
    .wr_data_i, .cmp_o(cmp_val), .match_o(match), .wrap_o(wrap)
  );

  ect_irq u_irq (
    .clk_i, .rst_ni, .fire_i(fire), .active_i(active), .lvl_i(cfg.lvl),
    .sts_clr_i, .irq_o, .sts_o
  );
endmodule

// File: rtl/ect_channel_chk.sv
module ect_channel_chk
  import ect_pkg::*;
#(
  parameter  int unsigned HALF_W = 32,
  localparam int unsigned CNT_W  = 2 * HALF_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             glb_en_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic             sts_clr_i,
  input logic             irq_o,
  input logic             sts_o,
  input ch_cfg_t          cfg,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] cmp_val,
  input logic             fire
);
  AST_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg.en && glb_en_i) |-> !irq_o); // R10
  AST_LVL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.lvl && cfg.en && glb_en_i && sts_o) |-> irq_o); // R7
  AST_EDGE_NO_STS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.lvl |=> !sts_o); // R7
  AST_STS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_clr_i && !fire) |=> !sts_o); // R8
  AST_SETV_SELF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_sel_i == 2'd1 || wr_sel_i == 2'd2)) |=> !cfg.setv); // R3
  AST_M32_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.m32 |-> (cmp_val[CNT_W-1:HALF_W] == '0 && period[CNT_W-1:HALF_W] == '0)); // R9
endmodule

bind ect_channel ect_channel_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .glb_en_i(glb_en_i), .wr_en_i(wr_en_i),
  .wr_sel_i(wr_sel_i), .sts_clr_i(sts_clr_i), .irq_o(irq_o), .sts_o(sts_o),
  .cfg(cfg), .period(period), .cmp_val(cmp_val), .fire(fire)
);

// File: tb/tb_ect_channel.sv
`timescale 1ns/1ps
module tb_ect_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] count = 64'd5;
  logic        glb = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  sel = 2'd3;
  logic [31:0] data = '0;
  logic        clr = 1'b0;
  logic        irq, sts;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ect_channel dut (
    .clk_i(clk), .rst_ni(rst_n), .count_i(count), .glb_en_i(glb),
    .wr_en_i(wr_en), .wr_sel_i(sel), .wr_data_i(data), .sts_clr_i(clr),
    .irq_o(irq), .sts_o(sts)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s count=%0h act=%0b exp=%0b", req, count, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1'b1; sel = s; data = d;
    @(negedge clk);
    wr_en = 1'b0; sel = 2'd3;
  endtask

  task automatic tick(input logic [63:0] c);
    count = c;
    @(negedge clk);
  endtask

  task automatic ack();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 sts after reset", sts, 1'b0);

    // reset comparator is all-ones
    tick(64'hFFFF_FFFF_FFFF_FFFF);
    chk("R10 disabled no fire", sts, 1'b0);
    tick(64'd5);
    glb = 1'b1;
    wr(2'd0, 32'h09);              // en | level
    tick(64'hFFFF_FFFF_FFFF_FFFE);
    chk("R4 no early fire", sts, 1'b0);
    tick(64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1 all-ones comparator sts", sts, 1'b1);
    chk("R7 level irq", irq, 1'b1);
    tick(64'd5);
    chk("R7 level holds", irq, 1'b1);
    ack();
    chk("R8 sts cleared", sts, 1'b0);
    chk("R8 irq dropped", irq, 1'b0);

    // one-shot 64-bit sweep
    wr(2'd1, 32'd100);
    wr(2'd2, 32'd0);
    wr(2'd3, 32'd95);              // ignored selector (R2)
    for (int c = 95; c <= 105; c++) begin
      tick(64'(c));
      chk("R4 one-shot sweep", sts, c >= 100);
    end
    tick(64'd5);
    ack();
    wr(2'd2, 32'd1);
    tick(64'd100);
    chk("R4 high half compared", sts, 1'b0);
    tick(64'h1_0000_0064);
    chk("R4 full width match", sts, 1'b1);
    glb = 1'b0;
    tick(64'd5);
    chk("R10 global off irq", irq, 1'b0);
    chk("R10 global off sts", sts, 1'b0);
    tick(64'h1_0000_0064);
    chk("R10 no fire when off", sts, 1'b0);
    glb = 1'b1;
    tick(64'd5);

    // edge mode
    wr(2'd0, 32'h01);
    wr(2'd1, 32'd200);
    wr(2'd2, 32'd0);
    tick(64'd199);
    chk("R7 edge before", irq, 1'b0);
    tick(64'd200);
    chk("R7 edge pulse", irq, 1'b1);
    chk("R7 edge no sts", sts, 1'b0);
    tick(64'd201);
    chk("R7 pulse one cycle", irq, 1'b0);

    // periodic, edge: cmp 300 via set-value, interval 50
    wr(2'd0, 32'h13);
    wr(2'd1, 32'd300);
    wr(2'd1, 32'd50);
    wr(2'd2, 32'd0);
    for (int c = 290; c <= 420; c++) begin
      tick(64'(c));
      chk("R5 R3 periodic spacing", irq, (c >= 300) && ((c - 300) % 50 == 0));
    end
    tick(64'd450);
    chk("R5 match before jump", irq, 1'b1);
    for (int k = 0; k < 4; k++) begin
      tick(64'd575);
      chk("R5 catch-up silent", irq, 1'b0);
    end
    tick(64'd599);
    chk("R5 catch-up target", irq, 1'b0);
    tick(64'd600);
    chk("R5 catch-up lands ahead", irq, 1'b1);

    // 32-bit truncation
    tick(64'd5);
    wr(2'd0, 32'h08);
    wr(2'd1, 32'h10);
    wr(2'd2, 32'h5);
    wr(2'd0, 32'h0D);
    tick(64'h7_0000_0010);
    chk("R4 low 32 compared", sts, 1'b1);
    tick(64'd5);
    ack();
    wr(2'd0, 32'h09);
    tick(64'h10);
    chk("R9 upper half truncated", sts, 1'b1);
    tick(64'd5);
    ack();

    // 32-bit one-shot rollover
    wr(2'd0, 32'h0D);
    wr(2'd1, 32'h20);
    tick(64'hFFFF_FFFE);
    chk("R6 before rollover", sts, 1'b0);
    tick(64'hFFFF_FFFF);
    chk("R6 at all-ones", sts, 1'b0);
    tick(64'h1_0000_0000);
    chk("R6 rollover fires", sts, 1'b1);
    tick(64'h1_0000_0001);
    ack();
    chk("R8 ack after rollover", sts, 1'b0);
    tick(64'h1_0000_001F);
    chk("R4 before match", sts, 1'b0);
    tick(64'h1_0000_0020);
    chk("R4 match after rollover", sts, 1'b1);
    tick(64'h1_0000_0021);
    ack();
    tick(64'h1_FFFF_FFFF);
    tick(64'h2_0000_0000);
    chk("R6 rollover only once", sts, 1'b0);

    // 32-bit periodic: bit 31 of interval forced to zero
    wr(2'd0, 32'h17);
    wr(2'd1, 32'h8000_0010);
    tick(64'h8000_0010);
    chk("R3 m32 periodic first", irq, 1'b1);
    tick(64'h8000_0011);
    chk("R3 m32 pulse ends", irq, 1'b0);
    tick(64'h8000_0020);
    chk("R3 interval bit31 cleared", irq, 1'b1);

    // signed ordering across 32-bit rollover
    wr(2'd0, 32'h17);
    wr(2'd1, 32'hFFFF_FFF8);
    wr(2'd1, 32'h10);
    tick(64'hFFFF_FFF8);
    chk("R5 pre-rollover match", irq, 1'b1);
    tick(64'hFFFF_FFF8);
    chk("R5 no extra add", irq, 1'b0);
    tick(64'hFFFF_FFFF);
    chk("R5 quiet", irq, 1'b0);
    tick(64'h1_0000_0008);
    chk("R5 match past rollover", irq, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule